// File: doc/BRIEF.md
# Rank Power-Mode Controller

This block follows the power mode of a single memory rank and decides when that rank may sleep, when it must wake, and when it may escalate to self-refresh. It watches how many reads and writes are queued for the rank, which direction the data bus turns to next, how many activate, read and write events are still in flight, and the handshakes of the refresh sequencer. From these it moves among six modes and drives one-cycle strobes that tell the command layer to enter or leave power-down or self-refresh.

Self-refresh is reached by one path only. A refresh must start while the rank sits in precharge power-down. When that refresh ends, the rank drops into self-refresh instead of waking. Each low-power mode has a minimum residency before any exit. Each exit is followed by a programmable quiet time during which the block withholds its command-ready indication. Power-down exit and self-refresh exit have separate quiet times.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: While reset is active and after it is released, the mode is idle (code 0), the event count is 0, command-ready is high and all strobes are low.
- R2: Mode codes are idle=0, refreshing=1, self-refresh=2, precharge power-down=3, active=4, active power-down=5. From idle the priority is: refresh start goes to refreshing (with ref_ack), otherwise activate goes to active, otherwise a power-down request goes to precharge power-down.
- R3: Active leaves only to idle (on precharge-all) or to active power-down (on power-down request). Active power-down leaves only to active.
- R4: A request that is not legal in the current mode leaves the mode and the event count unchanged.
- R5: When a refresh ends, the rank enters self-refresh if the refresh started from precharge power-down and no wake condition holds. In every other case it enters idle.
- R6: The wake condition is a nonzero read count, or a nonzero write count while the next bus direction is write. The wake condition moves precharge power-down to idle, active power-down to active, and self-refresh to idle.
- R7: A power-down request is granted only when the read count is 0 and the event count is 0.
- R8: The event count rises by one for each issued event and for each accepted refresh start. It falls by one for each event completion and for each refresh end. Several of these in one cycle combine, and the count saturates at both ends.
- R9: low_power is high in either power-down mode, in self-refresh, and while refreshing after a start from precharge power-down.
- R10: No exit from a low-power mode happens until cfg_min_res cycles have passed after entry.
- R11: After a power-down exit, command-ready stays low for cfg_pd_exit cycles. After a self-refresh exit it stays low for cfg_sr_exit cycles. Activate and refresh start are ignored while command-ready is low.
- R12: pd_enter, pd_exit, sr_enter, sr_exit and ref_ack are single-cycle pulses in the cycle after the transition they mark, and at most one of the four entry and exit strobes is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_pending | input | QW | Reads queued for this rank |
| wr_pending | input | QW | Writes queued for this rank |
| bus_next_wr | input | 1 | Next bus direction is write |
| evt_issue | input | 1 | An activate, read or write was scheduled |
| evt_done | input | 1 | A scheduled event finished |
| req_act | input | 1 | Open a bank |
| req_pre_all | input | 1 | All banks were closed |
| pd_req | input | 1 | Controller asks the rank to power down |
| ref_start | input | 1 | Refresh sequencer wants to start a refresh |
| ref_done | input | 1 | Refresh sequencer reports the refresh finished |
| cfg_min_res | input | TW | Minimum residency in a low-power mode, in cycles |
| cfg_pd_exit | input | TW | Quiet cycles after a power-down exit |
| cfg_sr_exit | input | TW | Quiet cycles after a self-refresh exit |
| pwr_state | output | 3 | Current mode code |
| low_power | output | 1 | Rank is in, or heading into, a low-power mode |
| cmd_ready | output | 1 | Exit quiet time has elapsed |
| evt_count | output | EVW | Outstanding event count |
| ref_ack | output | 1 | Refresh start accepted |
| pd_enter | output | 1 | Power-down entry strobe |
| pd_exit | output | 1 | Power-down exit strobe |
| sr_enter | output | 1 | Self-refresh entry strobe |
| sr_exit | output | 1 | Self-refresh exit strobe |

## Verification
A refresh start and a wake condition can arrive in the same cycle while the rank rests in precharge power-down with its residency already spent. The bench builds this case by letting the residency run out, then raising a read count together with ref_start. It expects the refresh to win: the mode goes to refreshing with ref_ack and low_power high. When ref_done then arrives with the read still queued, the mode must go to idle rather than self-refresh, and sr_enter must stay low. A second collision fires an event issue and a refresh start together, then their two completions together. The bench judges this by the event count, which must read 2 and then 0.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

  typedef enum logic [2:0] {
    PS_IDLE   = 3'd0,
    PS_REF    = 3'd1,
    PS_SREF   = 3'd2,
    PS_PRE_PD = 3'd3,
    PS_ACT    = 3'd4,
    PS_ACT_PD = 3'd5
  } pwr_state_e;

  // rank must leave sleep: any read, or writes when the bus turns to write
  function automatic logic wake_needed(input logic rd_any, input logic wr_any,
                                       input logic bus_wr);
    return rd_any || (bus_wr && wr_any);
  endfunction

  // asleep, or refreshing on the way to self-refresh
  function automatic logic is_low_power(input pwr_state_e st, input logic from_pd);
    return (st == PS_PRE_PD) || (st == PS_ACT_PD) || (st == PS_SREF) ||
           ((st == PS_REF) && from_pd);
  endfunction

endpackage

// File: rtl/rank_evt_counter.sv
module rank_evt_counter #(
  parameter int EVW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc_evt,
  input  logic           inc_ref,
  input  logic           dec_evt,
  input  logic           dec_ref,
  output logic [EVW-1:0] count
);

  localparam logic [EVW+1:0] MAXV = {2'b00, {EVW{1'b1}}};

  function automatic logic [EVW-1:0] step(input logic [EVW-1:0] c,
                                          input logic [1:0] up,
                                          input logic [1:0] dn);
    logic [EVW+1:0] t;
    t = {2'b00, c} + {{EVW{1'b0}}, up};
    if (t < {{EVW{1'b0}}, dn}) return '0;
    t = t - {{EVW{1'b0}}, dn};
    if (t > MAXV) return '1;
    return t[EVW-1:0];
  endfunction

  logic [1:0] ups, dns;
  assign ups = {1'b0, inc_evt} + {1'b0, inc_ref};
  assign dns = {1'b0, dec_evt} + {1'b0, dec_ref};

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= step(count, ups, dns);
  end

endmodule

// File: rtl/rank_down_timer.sv
module rank_down_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import rank_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake,
  input  logic       entry_ok,
  input  logic       res_done,
  input  logic       cmd_ok,
  input  logic       req_act,
  input  logic       req_pre_all,
  input  logic       pd_req,
  input  logic       ref_start,
  input  logic       ref_done,
  output pwr_state_e state,
  output logic       from_pd,
  output logic       ref_accept,
  output logic       ref_finish,
  output logic       go_pd,
  output logic       go_sr,
  output logic       leave_pd,
  output logic       leave_sr,
  output logic       ref_ack,
  output logic       pd_enter,
  output logic       pd_exit,
  output logic       sr_enter,
  output logic       sr_exit
);

  pwr_state_e nxt;
  logic       from_pd_nxt;

  always_comb begin
    nxt         = state;
    from_pd_nxt = from_pd;
    ref_accept  = 1'b0;
    ref_finish  = 1'b0;
    go_pd       = 1'b0;
    go_sr       = 1'b0;
    leave_pd    = 1'b0;
    leave_sr    = 1'b0;
    case (state)
      PS_IDLE: begin
        if (ref_start && cmd_ok) begin
          nxt = PS_REF; ref_accept = 1'b1; from_pd_nxt = 1'b0;
        end else if (req_act && cmd_ok) begin
          nxt = PS_ACT;
        end else if (pd_req && entry_ok) begin
          nxt = PS_PRE_PD; go_pd = 1'b1;
        end
      end
      PS_PRE_PD: begin
        if (ref_start && cmd_ok) begin
          nxt = PS_REF; ref_accept = 1'b1; from_pd_nxt = 1'b1;
        end else if (wake && res_done) begin
          nxt = PS_IDLE; leave_pd = 1'b1;
        end
      end
      PS_REF: begin
        if (ref_done) begin
          ref_finish = 1'b1;
          if (from_pd && !wake) begin
            nxt = PS_SREF; go_sr = 1'b1;
          end else begin
            nxt = PS_IDLE;
          end
          from_pd_nxt = 1'b0;
        end
      end
      PS_SREF: begin
        if (wake && res_done) begin
          nxt = PS_IDLE; leave_sr = 1'b1;
        end
      end
      PS_ACT: begin
        if (req_pre_all) begin
          nxt = PS_IDLE;
        end else if (pd_req && entry_ok) begin
          nxt = PS_ACT_PD; go_pd = 1'b1;
        end
      end
      PS_ACT_PD: begin
        if (wake && res_done) begin
          nxt = PS_ACT; leave_pd = 1'b1;
        end
      end
      default: nxt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PS_IDLE;
      from_pd  <= 1'b0;
      ref_ack  <= 1'b0;
      pd_enter <= 1'b0;
      pd_exit  <= 1'b0;
      sr_enter <= 1'b0;
      sr_exit  <= 1'b0;
    end else begin
      state    <= nxt;
      from_pd  <= from_pd_nxt;
      ref_ack  <= ref_accept;
      pd_enter <= go_pd;
      pd_exit  <= leave_pd;
      sr_enter <= go_sr;
      sr_exit  <= leave_sr;
    end
  end

endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl
  import rank_pwr_pkg::*;
#(
  parameter int QW  = 4,
  parameter int EVW = 4,
  parameter int TW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [QW-1:0]  rd_pending,
  input  logic [QW-1:0]  wr_pending,
  input  logic           bus_next_wr,
  input  logic           evt_issue,
  input  logic           evt_done,
  input  logic           req_act,
  input  logic           req_pre_all,
  input  logic           pd_req,
  input  logic           ref_start,
  input  logic           ref_done,
  input  logic [TW-1:0]  cfg_min_res,
  input  logic [TW-1:0]  cfg_pd_exit,
  input  logic [TW-1:0]  cfg_sr_exit,
  output logic [2:0]     pwr_state,
  output logic           low_power,
  output logic           cmd_ready,
  output logic [EVW-1:0] evt_count,
  output logic           ref_ack,
  output logic           pd_enter,
  output logic           pd_exit,
  output logic           sr_enter,
  output logic           sr_exit
);

  // named internal events, visible to the bound checker
  logic       wake_req;
  logic       entry_ok;
  logic       res_done;
  logic       ref_accept;
  logic       ref_finish;
  logic       go_pd, go_sr, leave_pd, leave_sr;
  logic       from_pd;
  pwr_state_e state;
  logic [TW-1:0] exit_len;

  assign wake_req = wake_needed(rd_pending != '0, wr_pending != '0, bus_next_wr);
  assign entry_ok = (rd_pending == '0) && (evt_count == '0);
  assign exit_len = leave_sr ? cfg_sr_exit : cfg_pd_exit;

  rank_pwr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake       (wake_req),
    .entry_ok   (entry_ok),
    .res_done   (res_done),
    .cmd_ok     (cmd_ready),
    .req_act    (req_act),
    .req_pre_all(req_pre_all),
    .pd_req     (pd_req),
    .ref_start  (ref_start),
    .ref_done   (ref_done),
    .state      (state),
    .from_pd    (from_pd),
    .ref_accept (ref_accept),
    .ref_finish (ref_finish),
    .go_pd      (go_pd),
    .go_sr      (go_sr),
    .leave_pd   (leave_pd),
    .leave_sr   (leave_sr),
    .ref_ack    (ref_ack),
    .pd_enter   (pd_enter),
    .pd_exit    (pd_exit),
    .sr_enter   (sr_enter),
    .sr_exit    (sr_exit)
  );

  rank_evt_counter #(.EVW(EVW)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_evt(evt_issue),
    .inc_ref(ref_accept),
    .dec_evt(evt_done),
    .dec_ref(ref_finish),
    .count  (evt_count)
  );

  // residency timer: armed on entry to any sleep mode
  rank_down_timer #(.TW(TW)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (go_pd || go_sr),
    .load_val(cfg_min_res),
    .expired (res_done)
  );

  // exit quiet timer: armed on leaving any sleep mode
  rank_down_timer #(.TW(TW)) u_exit (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (leave_pd || leave_sr),
    .load_val(exit_len),
    .expired (cmd_ready)
  );

  assign pwr_state = state;
  assign low_power = is_low_power(state, from_pd);

endmodule

// File: rtl/rank_pwr_chk.sv
module rank_pwr_chk
  import rank_pwr_pkg::*;
#(
  parameter int EVW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     pwr_state,
  input logic           low_power,
  input logic           cmd_ready,
  input logic [EVW-1:0] evt_count,
  input logic           pd_req,
  input logic           pd_enter,
  input logic           pd_exit,
  input logic           sr_enter,
  input logic           sr_exit,
  input logic           wake_req,
  input logic           res_done
);

  assert_sref_via_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_SREF && $past(pwr_state) != PS_SREF) |-> $past(pwr_state) == PS_REF);

  assert_actpd_from_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_ACT_PD && $past(pwr_state) != PS_ACT_PD) |-> $past(pwr_state) == PS_ACT);

  assert_sref_exit_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == PS_SREF && pwr_state != PS_SREF) |-> pwr_state == PS_IDLE);

  assert_sleep_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_SREF || pwr_state == PS_PRE_PD || pwr_state == PS_ACT_PD) |-> low_power);

  assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_enter, pd_exit, sr_enter, sr_exit}));

  assert_quiet_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_IDLE && !cmd_ready) |=> (pwr_state != PS_ACT && pwr_state != PS_REF));

  assert_entry_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_IDLE && pd_req && evt_count != '0) |=> pwr_state != PS_PRE_PD);

  assert_residency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_SREF && !res_done) |=> pwr_state == PS_SREF);

  assert_stay_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_SREF && !wake_req) |=> pwr_state == PS_SREF);

endmodule

bind rank_pwr_ctrl rank_pwr_chk #(.EVW(EVW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_state(pwr_state),
  .low_power(low_power),
  .cmd_ready(cmd_ready),
  .evt_count(evt_count),
  .pd_req   (pd_req),
  .pd_enter (pd_enter),
  .pd_exit  (pd_exit),
  .sr_enter (sr_enter),
  .sr_exit  (sr_exit),
  .wake_req (wake_req),
  .res_done (res_done)
);

// File: tb/tb_rank_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_rank_pwr_ctrl;

  localparam int QW = 4, EVW = 4, TW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [QW-1:0] rd_pending, wr_pending;
  logic bus_next_wr, evt_issue, evt_done, req_act, req_pre_all, pd_req, ref_start, ref_done;
  logic [TW-1:0] cfg_min_res, cfg_pd_exit, cfg_sr_exit;
  logic [2:0] pwr_state;
  logic low_power, cmd_ready, ref_ack, pd_enter, pd_exit, sr_enter, sr_exit;
  logic [EVW-1:0] evt_count;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rank_pwr_ctrl #(.QW(QW), .EVW(EVW), .TW(TW)) dut (.*);

  typedef struct packed {
    logic [3:0] rd; logic [3:0] wr;
    logic bw, ei, ed, act, pre, pd, rs, rf;
    logic [2:0] st; logic lp;
  } vec_t;

  // cfg: residency 2, power-down quiet 3, self-refresh quiet 6
  localparam vec_t VEC [25] = '{
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd3,1'b1}, // R2 idle->pre pd
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd3,1'b1}, // R10
    '{4'd1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd3,1'b1}, // R10 too early
    '{4'd1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0}, // R6 wake
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0}, // R11 act blocked
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0}, // R11
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0}, // R11
    '{4'd0,4'd0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0}, // R2 activate
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd4,1'b0}, // R7 busy
    '{4'd0,4'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0}, // R8 drain
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd5,1'b1}, // R3 act pd
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd5,1'b1}, // R4 illegal
    '{4'd0,4'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd5,1'b1}, // R6 read dir
    '{4'd0,4'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0}, // R6 write dir
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0}, // R3 precharge
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'd0,1'b0}, // R11 ref blocked
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0}, // R11
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'd1,1'b0}, // R2 refresh
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd0,1'b0}, // R5 back to idle
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd3,1'b1}, // R7 granted
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'd1,1'b1}, // R9 heading down
    '{4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd2,1'b1}, // R5 to self-refresh
    '{4'd1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,1'b1}, // R10
    '{4'd1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,1'b1}, // R10
    '{4'd1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0}  // R6 leave sr
  };
  localparam string TAG [25] = '{"R2","R10","R10","R6","R11","R11","R11","R2","R7","R8",
    "R3","R4","R6","R6","R3","R11","R11","R2","R5","R7","R9","R5","R10","R10","R6"};

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rd_pending = '0; wr_pending = '0; bus_next_wr = 0; evt_issue = 0; evt_done = 0;
    req_act = 0; req_pre_all = 0; pd_req = 0; ref_start = 0; ref_done = 0;
  endtask

  // drive at negedge, let one posedge pass, sample 1ns later
  task automatic apply(input vec_t v);
    @(negedge clk);
    rd_pending = v.rd; wr_pending = v.wr; bus_next_wr = v.bw; evt_issue = v.ei;
    evt_done = v.ed; req_act = v.act; req_pre_all = v.pre; pd_req = v.pd;
    ref_start = v.rs; ref_done = v.rf;
    @(posedge clk); #1;
  endtask

  task automatic tick();
    @(negedge clk); idle_inputs(); @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_inputs(); rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  function automatic vec_t mk(input logic [3:0] rd, input logic rs, input logic rf,
                              input logic pd, input logic ei, input logic ed);
    vec_t v = '0;
    v.rd = rd; v.rs = rs; v.rf = rf; v.pd = pd; v.ei = ei; v.ed = ed;
    return v;
  endfunction

  initial begin
    idle_inputs();
    cfg_min_res = 8'd2; cfg_pd_exit = 8'd3; cfg_sr_exit = 8'd6;
    rst_n = 0;
    repeat (2) @(posedge clk); #1;
    // R1 during reset
    check("R1", "state in reset", pwr_state, 0);
    check("R1", "cmd_ready in reset", cmd_ready, 1);
    do_reset(); #1;
    check("R1", "state after reset", pwr_state, 0);
    check("R1", "evt_count after reset", evt_count, 0);
    check("R1", "strobes after reset", {ref_ack, pd_enter, pd_exit, sr_enter, sr_exit}, 0);

    for (int i = 0; i < 25; i++) begin
      apply(VEC[i]);
      check(TAG[i], $sformatf("state vec %0d", i), pwr_state, VEC[i].st);
      check(TAG[i], $sformatf("low_power vec %0d", i), low_power, VEC[i].lp);
      if (i == 0)  check("R12", "pd_enter pulse", pd_enter, 1);
      if (i == 1)  check("R12", "pd_enter cleared", pd_enter, 0);
      if (i == 3)  check("R12", "pd_exit pulse", pd_exit, 1);
      if (i == 4)  check("R11", "cmd_ready low after pd exit", cmd_ready, 0);
      if (i == 6)  check("R11", "cmd_ready after pd quiet", cmd_ready, 1);
      if (i == 11) check("R4", "count unchanged", evt_count, 0);
      if (i == 17) check("R12", "ref_ack pulse", ref_ack, 1);
      if (i == 21) check("R12", "sr_enter pulse", sr_enter, 1);
      if (i == 24) check("R12", "sr_exit pulse", sr_exit, 1);
    end
    // R11 self-refresh quiet of 6 cycles
    repeat (5) tick();
    check("R11", "cmd_ready before sr quiet end", cmd_ready, 0);
    tick();
    check("R11", "cmd_ready at sr quiet end", cmd_ready, 1);

    // collision: wake and refresh start together in precharge power-down
    do_reset();
    apply(mk(4'd0, 0, 0, 1, 0, 0));
    tick(); tick();
    apply(mk(4'd2, 1, 0, 0, 0, 0));
    check("R2", "refresh wins over wake", pwr_state, 1);
    check("R9", "low_power while heading down", low_power, 1);
    check("R12", "ref_ack on collision", ref_ack, 1);
    apply(mk(4'd2, 0, 1, 0, 0, 0));
    check("R5", "wake pending -> idle", pwr_state, 0);
    check("R5", "no sr_enter with wake", sr_enter, 0);
    check("R8", "count back to zero", evt_count, 0);

    // combined count updates
    apply(mk(4'd0, 1, 0, 0, 1, 0));
    check("R8", "issue plus refresh start", evt_count, 2);
    apply(mk(4'd0, 0, 1, 0, 0, 1));
    check("R8", "done plus refresh end", evt_count, 0);
    check("R5", "idle after refresh from idle", pwr_state, 0);
    // saturation at zero
    apply(mk(4'd0, 0, 0, 0, 0, 1));
    check("R8", "no underflow", evt_count, 0);
    // reads block power-down
    apply(mk(4'd1, 0, 0, 1, 0, 0));
    check("R7", "reads block entry", pwr_state, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule